// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Lane

This block is one lane of a vector datapath that sits beside a SIMD processor. Each cycle it may accept one operation: two signed Q15 operands and a signed 32-bit accumulator. It returns `sat_add(acc, sat_fmul(a, b))` three cycles later. The arithmetic follows the fixed-point basic operators used by low-bit-rate speech coders, bit for bit. The fractional multiply forms the signed product and doubles it. The add that follows clamps to the 32-bit range instead of wrapping.

Every result carries an overflow flag. The flag is set when either step had to saturate. Both the input and the output are qualified by a valid bit. There are no stalls, so back-to-back operations flow through at full rate. A synchronous reset empties the pipeline.

Top module: `frac_mac_lane`

## Requirements
- R1: The result equals the saturated sum of the accumulator and the saturated fractional product. The product is formed first, as `a*b*2` (signed), and the add is done second.
- R2: When both operands are the most negative operand value (0x8000 for OPW=16), the product becomes 0x7FFFFFFF and the overflow flag is raised.
- R3: If the exact sum exceeds the largest positive accumulator value, the result is clamped to 0x7FFFFFFF and the overflow flag is set.
- R4: If the exact sum falls below the most negative accumulator value, the result is clamped to 0x80000000 and the overflow flag is set.
- R5: The output overflow flag is the OR of the multiply-step and add-step saturation events of the same operation. It is 0 when neither step saturates.
- R6: `out_vld` follows `in_vld` by exactly three clock cycles. A new operation is accepted on every cycle, and each result appears in issue order.
- R7: A synchronous reset clears every valid bit, so `out_vld` is 0 on the cycle after reset is sampled and stays 0 until new operations drain through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input operation valid |
| in_a | input | OPW | Signed fractional operand A |
| in_b | input | OPW | Signed fractional operand B |
| in_acc | input | 2*OPW | Signed incoming accumulator |
| out_vld | output | 1 | Result valid |
| out_res | output | 2*OPW | Saturated accumulate result |
| out_ovf | output | 1 | Saturation occurred in multiply or add |

## Verification
The bench builds the lane with the default OPW of 16, which gives a 32-bit accumulator. That is the width at which the codec operators are defined. At this width the bench can reach the exact corner values: 0x8000 times 0x8000, the 0x7FFFFFFF and 0x80000000 clamps, and a doubled product that saturates while a negative accumulator then pulls it back into range. These cases are fed back to back and also with gaps between them. A software model with 64-bit intermediates gives the expected values. Chained accumulations walk the result up to the positive limit and down to the negative limit.

// File: rtl/frac_mac_lane.sv
module frac_mac_lane #(
  parameter int OPW = 16,
  localparam int ACCW = 2 * OPW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_vld,
  input  logic signed [OPW-1:0]  in_a,
  input  logic signed [OPW-1:0]  in_b,
  input  logic signed [ACCW-1:0] in_acc,
  output logic                   out_vld,
  output logic signed [ACCW-1:0] out_res,
  output logic                   out_ovf
);

  localparam logic [OPW-1:0]  OP_MIN  = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] ACC_MAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] ACC_MIN = {1'b1, {(ACCW-1){1'b0}}};

  logic                   s1_vld, s2_vld;
  logic signed [OPW-1:0]  s1_a, s1_b;
  logic signed [ACCW-1:0] s1_acc, s2_acc, s2_prod;
  logic                   s2_ovf;

  // stage 1 -> 2: fractional multiply
  logic signed [ACCW-1:0] raw_prod;
  logic                   mul_sat;
  logic signed [ACCW-1:0] frac_prod;

  assign raw_prod  = s1_a * s1_b;
  assign mul_sat   = (s1_a == OP_MIN) && (s1_b == OP_MIN);
  assign frac_prod = mul_sat ? ACC_MAX : (raw_prod <<< 1);

  // stage 2 -> 3: saturating add
  logic signed [ACCW:0]   wide_sum;
  logic                   add_sat;
  logic signed [ACCW-1:0] sat_sum;

  assign wide_sum = {s2_acc[ACCW-1], s2_acc} + {s2_prod[ACCW-1], s2_prod};
  assign add_sat  = wide_sum[ACCW] ^ wide_sum[ACCW-1];
  assign sat_sum  = add_sat ? (wide_sum[ACCW] ? ACC_MIN : ACC_MAX) : wide_sum[ACCW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      s1_vld  <= in_vld;
      s2_vld  <= s1_vld;
      out_vld <= s2_vld;
    end
  end

  always_ff @(posedge clk) begin
    s1_a    <= in_a;
    s1_b    <= in_b;
    s1_acc  <= in_acc;
    s2_prod <= frac_prod;
    s2_acc  <= s1_acc;
    s2_ovf  <= mul_sat;
    out_res <= sat_sum;
    out_ovf <= s2_ovf | add_sat;
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3))); // R6

  AST_MUL_CORNER: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_a == OP_MIN && s1_b == OP_MIN) |=> (s2_prod == ACC_MAX && s2_ovf)); // R2

  AST_OVF_CARRY: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_ovf) |=> (out_vld && out_ovf)); // R5

  AST_NO_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && !s2_acc[ACCW-1] && !s2_prod[ACCW-1]) |=> !out_res[ACCW-1]); // R3

  AST_NO_NEG_WRAP: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_acc[ACCW-1] && s2_prod[ACCW-1]) |=> out_res[ACCW-1]); // R4

  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !out_vld); // R7

endmodule

// File: tb/frac_mac_lane_test.sv
`timescale 1ns/1ps
module frac_mac_lane_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] in_a = '0, in_b = '0;
  logic signed [31:0] in_acc = '0;
  logic out_vld;
  logic signed [31:0] out_res;
  logic out_ovf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frac_mac_lane #(.OPW(16)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .in_acc(in_acc), .out_vld(out_vld), .out_res(out_res), .out_ovf(out_ovf));

  // {a[15:0], b[15:0], acc[31:0]}
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    64'h0001_0001_00000000,
    64'h8000_8000_00000000,
    64'h8000_8000_FFFFFFFF,
    64'h7FFF_7FFF_00000000,
    64'h7FFF_7FFF_7FFFFFFF,
    64'h8000_7FFF_80000000,
    64'hFFFF_0001_00000005,
    64'h1234_FF00_00001000,
    64'h8000_0001_00000000,
    64'h0000_0000_80000000
  };

  function automatic void model(input logic signed [15:0] a, input logic signed [15:0] b,
                                input logic signed [31:0] acc,
                                output logic signed [31:0] res, output logic ovf);
    longint p, s;
    ovf = 1'b0;
    if (a == -16'sd32768 && b == -16'sd32768) begin
      p = 64'sd2147483647; ovf = 1'b1;
    end else p = longint'(a) * longint'(b) * 2;
    s = longint'(acc) + p;
    if (s > 64'sd2147483647) begin s = 64'sd2147483647; ovf = 1'b1; end
    if (s < -64'sd2147483648) begin s = -64'sd2147483648; ovf = 1'b1; end
    res = s[31:0];
  endfunction

  logic        h_vld [3];
  logic [31:0] h_res [3];
  logic        h_ovf [3];
  string       h_tag [3];

  task automatic check_out();
    total++;
    if (out_vld !== h_vld[2]) begin
      bad++;
      $display("FAIL %s R6 out_vld actual=%0b expected=%0b", h_tag[2], out_vld, h_vld[2]);
    end else if (h_vld[2]) begin
      total++;
      if (out_res !== h_res[2] || out_ovf !== h_ovf[2]) begin
        bad++;
        $display("FAIL %s res/ovf actual=%h/%0b expected=%h/%0b",
                 h_tag[2], out_res, out_ovf, h_res[2], h_ovf[2]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] acc, input string tag);
    logic [31:0] r; logic o;
    @(negedge clk);
    check_out();
    for (int i = 2; i > 0; i--) begin
      h_vld[i] = h_vld[i-1]; h_res[i] = h_res[i-1]; h_ovf[i] = h_ovf[i-1]; h_tag[i] = h_tag[i-1];
    end
    model(a, b, acc, r, o);
    h_vld[0] = v; h_res[0] = r; h_ovf[0] = o; h_tag[0] = tag;
    in_vld = v; in_a = a; in_b = b; in_acc = acc;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, "R6 drain");
  endtask

  task automatic hold_reset(input int n, input string tag);
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    for (int i = 0; i < 3; i++) begin h_vld[i] = 1'b0; h_tag[i] = tag; end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      total++;
      if (out_vld !== 1'b0) begin
        bad++;
        $display("FAIL %s out_vld actual=%0b expected=0", tag, out_vld);
      end
    end
    rst = 1'b0;
  endtask

  task automatic chain(input logic [15:0] a, input logic [15:0] b, input logic [31:0] start,
                       input int n, input logic [31:0] lim, input string tag);
    logic [31:0] acc, r; logic o;
    acc = start;
    for (int i = 0; i < n; i++) begin
      step(1'b1, a, b, acc, tag);
      flush();
      model(a, b, acc, r, o);
      acc = r;
    end
    total++;
    if (out_res !== lim || out_ovf !== 1'b1) begin
      bad++;
      $display("FAIL %s chain end actual=%h/%0b expected=%h/1", tag, out_res, out_ovf, lim);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin h_vld[i] = 1'b0; h_res[i] = '0; h_ovf[i] = 1'b0; h_tag[i] = "R7"; end
    repeat (3) @(negedge clk);
    total++;
    if (out_vld !== 1'b0) begin bad++; $display("FAIL R7 reset out_vld actual=%0b expected=0", out_vld); end
    rst = 1'b0;

    // table walk, back to back (R1 R2 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++)
      step(1'b1, VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], "R1 table");
    flush();

    // same table with bubbles between ops (R6)
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], "R6 gapped");
      if (i % 2 == 0) step(1'b0, 16'h5555, 16'h5555, 32'h12345678, "R6 bubble");
    end
    flush();

    // R2 and R5 directed
    step(1'b1, 16'h8000, 16'h8000, 32'h80000000, "R2 R5 min*min+min");
    step(1'b1, 16'h4000, 16'h4000, 32'h00000000, "R5 no ovf");
    step(1'b1, 16'h8000, 16'h8000, 32'h00000001, "R2 R3 min*min+1");
    flush();

    // accumulate toward both limits
    chain(16'h7FFF, 16'h7FFF, 32'h00000000, 4, 32'h7FFFFFFF, "R3");
    chain(16'h8000, 16'h7FFF, 32'h00000000, 4, 32'h80000000, "R4");

    // reset mid-flight (R7)
    step(1'b1, 16'h0100, 16'h0100, 32'h0, "R7 pre");
    step(1'b1, 16'h0200, 16'h0100, 32'h0, "R7 pre");
    hold_reset(3, "R7 midflight");
    flush();
    step(1'b1, 16'h0003, 16'h0004, 32'h00000010, "R7 after");
    flush();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule